// File: doc/BRIEF.md
# VME Register Slave with Deferred Write Acknowledge

This block is the bus front end of a register-based board on a VME backplane. It is an A24/D16 slave for single-word transfers. It accepts a cycle only when two things hold: the address modifier names a standard user or supervisory data access, and the top address byte matches an 8-bit board-select value. The low address bits A[8:1] pick one word out of a 256-word window. A[15:9] play no part in decoding, so they are not brought into the block. Every decoded access is acknowledged with DTACK, and bus error is never driven.

Behind the window sit setting registers for two banks of 8-bit DAC channels (laser drive and receiver threshold), a set of 5-bit clock-phase delays and a reset/control word. Writing a DAC channel or a phase delay starts a slow back-end load, modelled as a busy timer whose length in clock cycles is a parameter. The write that starts the load completes at once. Any later write waits, with DTACK held off, until the load is done. Reads never wait.

A status word reports the busy flags and an interlock input. Reading the power-monitor word returns the result of the previous conversion and starts a new one. All bus inputs are assumed to be synchronous to `clk`.

Top module: `vme_slow_slave`

## Requirements
- R1: A cycle is decoded only when `am` is 6'h39 or 6'h3D. With any other code, `dtack_n` stays high and no register changes.
- R2: A cycle is decoded only when `a_hi` equals `board_sel`. `a_word` selects the word, and A[15:9] are not decoded.
- R3: A decoded read is acknowledged one clock after the strobe is seen, even while a slow load is busy. `berr_n` is never low. Unmapped words read as 0x0000, including DAC words past the last channel.
- R4: `dtack_n` stays low until `ds_n` is released and goes high one clock after that. It is high during reset.
- R5: A write to laser DAC word 0x10+i or threshold DAC word 0x20+i stores the low 8 bits and starts a DAC load of DAC_CYC cycles. Status bit 1 is high while the load runs.
- R6: A write to phase word 0x30+j with a value from 0 to 24 starts a phase load of PH_CYC cycles, shown on status bit 0. A value above 24 is discarded: it changes nothing and starts no load.
- R7: The first valid phase write after reset only resets the delay chips. It starts a phase load but leaves every phase register unchanged.
- R8: The write that starts a load is acknowledged after one clock. A write arriving while status bit 0 or bit 1 is high gets no DTACK until both are low, and then takes effect.
- R9: A read of word 0x01 returns the result of the previous conversion. That result is 0 after reset. If the converter is idle, the read also starts a conversion of ADC_CYC cycles, shown on status bit 2. When the conversion ends, `mon_level` is captured. A read during a conversion does not restart it.
- R10: Word 0x02 holds two readable bits. Bit 0 drives `enc_rst`. While bit 1 is set, every DAC setting is held at 0 and DAC writes are lost.
- R11: Status word 0x00 reads {12'b0, interlock, adc busy, DAC busy, phase busy}. Writes to words 0x00 and 0x01 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| board_sel | input | 8 | Board-select switch value compared with A[23:16] |
| am | input | 6 | Address modifier |
| a_hi | input | 8 | Address bits A[23:16] |
| a_word | input | 8 | Address bits A[8:1], word select |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| write_n | input | 1 | Low for a write cycle |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid while `rdata_oe` is high |
| rdata_oe | output | 1 | Read data drive enable |
| dtack_n | output | 1 | Data acknowledge, active low |
| berr_n | output | 1 | Bus error, never asserted |
| interlock | input | 1 | Laser guard interlock state |
| mon_level | input | MON_W | Power-monitor level sampled at the end of a conversion |
| laser_dac | output | N_CH*8 | Laser drive settings, channel i at [8i+7:8i] |
| thresh_dac | output | N_CH*8 | Receiver threshold settings, channel i at [8i+7:8i] |
| phase_dly | output | N_PH*5 | Clock-phase settings, delay j at [5j+4:5j] |
| enc_rst | output | 1 | Encoder reset level, bit 0 of word 0x02 |

## Verification
The bench sweeps all 64 modifier codes and all 256 board-select bytes. A slave that decodes too loosely would answer a foreign cycle, and one that decodes too tightly would leave the master to time out. It also sweeps phase values 0 to 31. A design that clamps or truncates out-of-range values would show a changed delay, and one that treats the first write as real would show the dummy value. Writes issued during a load must show a delayed acknowledge and must then land. A design that drops a held write or stalls reads would fail that check. Finally, the monitor is read twice during one conversion, and a restart on the second read would show as a late result.

// File: rtl/vme_slow_pkg.sv
// Package: shared constants for the VME register slave.
// Holds the accepted address modifiers, the word map, the status bit
// positions and the bus handshake state type.
package vme_slow_pkg;
    localparam logic [5:0] AM_USER  = 6'h39;
    localparam logic [5:0] AM_SUPER = 6'h3D;

    localparam logic [7:0] W_STATUS      = 8'h00;
    localparam logic [7:0] W_MONITOR     = 8'h01;
    localparam logic [7:0] W_RESET       = 8'h02;
    localparam logic [7:0] W_LASER_BASE  = 8'h10;
    localparam logic [7:0] W_THRESH_BASE = 8'h20;
    localparam logic [7:0] W_PHASE_BASE  = 8'h30;

    localparam int ST_PHASE = 0;
    localparam int ST_DAC   = 1;
    localparam int ST_ADC   = 2;
    localparam int ST_INTLK = 3;

    localparam logic [15:0] PHASE_MAX = 16'd24;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HOLD = 2'd1,
        S_ACK  = 2'd2
    } bus_state_t;
endpackage

// File: rtl/vme_addr_match.sv
// Module: vme_addr_match
// Decides whether the current bus cycle belongs to this board.
// Assumes: only standard data modifiers are served, and A[23:16] is
// compared against the board-select switch value.
module vme_addr_match
    import vme_slow_pkg::*;
(
    input  logic [5:0] am,
    input  logic [7:0] a_hi,
    input  logic [7:0] board_sel,
    output logic       hit
);
    logic am_ok;

    // Accept the two standard data-access modifiers only.
    always_comb begin
        am_ok = (am == AM_USER) || (am == AM_SUPER);
        hit   = am_ok && (a_hi == board_sel);
    end
endmodule

// File: rtl/slow_op_timer.sv
// Module: slow_op_timer
// Models a slow back-end operation as a down counter of CYC cycles.
// Assumes: a start pulse while busy is ignored; CYC is at least 1.
module slow_op_timer #(
    parameter int CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt_q;

    // Load on an idle start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (start && cnt_q == '0)   cnt_q <= CW'(CYC);
        else if (cnt_q != '0)            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    p_start_sets_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && cnt_q != CW'(1)) |=> busy);
endmodule

// File: rtl/vme_reg_bank.sv
// Module: vme_reg_bank
// Setting registers behind the window: laser and threshold DAC banks,
// clock-phase delays and the reset/control word. It raises start
// pulses for DAC and phase loads.
// Assumes: the caller issues wr_en only when a write is allowed to land.
module vme_reg_bank
    import vme_slow_pkg::*;
#(
    parameter int N_CH = 12,
    parameter int N_PH = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [7:0]          wr_word,
    input  logic [15:0]         wr_data,
    input  logic [7:0]          rd_word,
    output logic [15:0]         rd_data,
    output logic [N_CH*8-1:0]   laser_flat,
    output logic [N_CH*8-1:0]   thresh_flat,
    output logic [N_PH*5-1:0]   phase_flat,
    output logic                enc_rst,
    output logic                dac_start,
    output logic                phase_start
);
    logic [7:0]      laser_q  [N_CH];
    logic [7:0]      thresh_q [N_CH];
    logic [4:0]      phase_q  [N_PH];
    logic [1:0]      ctl_q;
    logic            phase_armed_q;
    logic [N_CH-1:0] laser_wr;
    logic [N_CH-1:0] thresh_wr;
    logic [N_PH-1:0] phase_wr;
    logic            phase_ok;

    // Decode which setting, if any, the current write targets.
    always_comb begin
        phase_ok = (wr_data <= PHASE_MAX);
        for (int g = 0; g < N_CH; g++) begin
            laser_wr[g]  = wr_en && (wr_word == W_LASER_BASE + 8'(g));
            thresh_wr[g] = wr_en && (wr_word == W_THRESH_BASE + 8'(g));
        end
        for (int g = 0; g < N_PH; g++)
            phase_wr[g] = wr_en && phase_ok && (wr_word == W_PHASE_BASE + 8'(g));
        dac_start   = (|laser_wr) || (|thresh_wr);
        phase_start = |phase_wr;
    end

    // Reset/control word: bit 0 encoder reset, bit 1 DAC clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ctl_q <= '0;
        else if (wr_en && wr_word == W_RESET) ctl_q <= wr_data[1:0];
    end

    // Arms the phase bank once the dummy first write has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n)           phase_armed_q <= 1'b0;
        else if (phase_start) phase_armed_q <= 1'b1;
    end

    genvar g;
    generate
        for (g = 0; g < N_CH; g++) begin : g_dac
            // One laser and one threshold channel; the clear bit wins.
            always_ff @(posedge clk) begin
                if (!rst_n || ctl_q[1]) begin
                    laser_q[g]  <= '0;
                    thresh_q[g] <= '0;
                end else begin
                    if (laser_wr[g])  laser_q[g]  <= wr_data[7:0];
                    if (thresh_wr[g]) thresh_q[g] <= wr_data[7:0];
                end
            end
            assign laser_flat[g*8 +: 8]  = laser_q[g];
            assign thresh_flat[g*8 +: 8] = thresh_q[g];
        end

        for (g = 0; g < N_PH; g++) begin : g_phase
            // One phase delay; stores only after the bank is armed.
            always_ff @(posedge clk) begin
                if (!rst_n)                             phase_q[g] <= '0;
                else if (phase_wr[g] && phase_armed_q)  phase_q[g] <= wr_data[4:0];
            end
            assign phase_flat[g*5 +: 5] = phase_q[g];

            p_phase_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
                phase_q[g] <= 5'd24);
        end
    endgenerate

    assign enc_rst = ctl_q[0];

    // Read-back mux for the setting words; anything else reads zero.
    always_comb begin
        rd_data = '0;
        if (rd_word == W_RESET) rd_data = {14'b0, ctl_q};
        for (int i = 0; i < N_CH; i++) begin
            if (rd_word == W_LASER_BASE + 8'(i))  rd_data = {8'h00, laser_q[i]};
            if (rd_word == W_THRESH_BASE + 8'(i)) rd_data = {8'h00, thresh_q[i]};
        end
        for (int i = 0; i < N_PH; i++)
            if (rd_word == W_PHASE_BASE + 8'(i)) rd_data = {11'b0, phase_q[i]};
    end

    p_dac_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[1] |=> (laser_flat == '0 && thresh_flat == '0));

    p_dummy_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_start && !phase_armed_q) |=> $stable(phase_flat));
endmodule

// File: rtl/vme_slow_slave.sv
// Module: vme_slow_slave (top)
// A24/D16 VME slave with a 256-word window. Reads are acknowledged at
// once. A write that arrives during a DAC or phase load is held, with
// DTACK withheld, until the load ends. Also holds the status word and
// the power-monitor converter model.
// Assumes: bus inputs are synchronous to clk; single transfers only.
module vme_slow_slave
    import vme_slow_pkg::*;
#(
    parameter int N_CH    = 12,
    parameter int N_PH    = 5,
    parameter int DAC_CYC = 800,
    parameter int PH_CYC  = 8000,
    parameter int ADC_CYC = 60,
    parameter int MON_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          board_sel,
    input  logic [5:0]          am,
    input  logic [7:0]          a_hi,
    input  logic [7:0]          a_word,
    input  logic                as_n,
    input  logic                ds_n,
    input  logic                write_n,
    input  logic [15:0]         wdata,
    output logic [15:0]         rdata,
    output logic                rdata_oe,
    output logic                dtack_n,
    output logic                berr_n,
    input  logic                interlock,
    input  logic [MON_W-1:0]    mon_level,
    output logic [N_CH*8-1:0]   laser_dac,
    output logic [N_CH*8-1:0]   thresh_dac,
    output logic [N_PH*5-1:0]   phase_dly,
    output logic                enc_rst
);
    localparam int PAD_W = 16 - MON_W;

    bus_state_t       state_q, state_d;
    logic             hit, strobe, hold;
    logic             do_read, do_write;
    logic             is_read_q;
    logic [15:0]      rdata_q, rd_mux, bank_rd;
    logic             dac_start, phase_start, adc_start;
    logic             dac_busy, ph_busy, adc_busy, adc_was_q;
    logic [MON_W-1:0] mon_q;

    vme_addr_match u_match (
        .am        (am),
        .a_hi      (a_hi),
        .board_sel (board_sel),
        .hit       (hit)
    );

    vme_reg_bank #(.N_CH(N_CH), .N_PH(N_PH)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (do_write),
        .wr_word     (a_word),
        .wr_data     (wdata),
        .rd_word     (a_word),
        .rd_data     (bank_rd),
        .laser_flat  (laser_dac),
        .thresh_flat (thresh_dac),
        .phase_flat  (phase_dly),
        .enc_rst     (enc_rst),
        .dac_start   (dac_start),
        .phase_start (phase_start)
    );

    slow_op_timer #(.CYC(DAC_CYC)) u_dac_tmr (
        .clk(clk), .rst_n(rst_n), .start(dac_start), .busy(dac_busy));
    slow_op_timer #(.CYC(PH_CYC)) u_ph_tmr (
        .clk(clk), .rst_n(rst_n), .start(phase_start), .busy(ph_busy));
    slow_op_timer #(.CYC(ADC_CYC)) u_adc_tmr (
        .clk(clk), .rst_n(rst_n), .start(adc_start), .busy(adc_busy));

    assign strobe    = !as_n && !ds_n;
    assign hold      = dac_busy || ph_busy;
    assign adc_start = do_read && (a_word == W_MONITOR);

    // Handshake decisions: read now, write now, or hold the write.
    always_comb begin
        state_d  = state_q;
        do_read  = 1'b0;
        do_write = 1'b0;
        case (state_q)
            S_IDLE: if (strobe && hit) begin
                if (write_n) begin
                    do_read = 1'b1;
                    state_d = S_ACK;
                end else if (hold) begin
                    state_d = S_HOLD;
                end else begin
                    do_write = 1'b1;
                    state_d  = S_ACK;
                end
            end
            S_HOLD: if (!strobe) begin
                state_d = S_IDLE;
            end else if (!hold) begin
                do_write = 1'b1;
                state_d  = S_ACK;
            end
            S_ACK: if (ds_n) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Handshake state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Read source selection: status, monitor result or setting bank.
    always_comb begin
        case (a_word)
            W_STATUS:  rd_mux = {12'b0, interlock, adc_busy, dac_busy, ph_busy};
            W_MONITOR: rd_mux = {{PAD_W{1'b0}}, mon_q};
            default:   rd_mux = bank_rd;
        endcase
    end

    // Capture read data and the transfer direction at commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q   <= '0;
            is_read_q <= 1'b0;
        end else if (do_read) begin
            rdata_q   <= rd_mux;
            is_read_q <= 1'b1;
        end else if (do_write) begin
            is_read_q <= 1'b0;
        end
    end

    // Converter model: latch the level when a conversion finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adc_was_q <= 1'b0;
            mon_q     <= '0;
        end else begin
            adc_was_q <= adc_busy;
            if (adc_was_q && !adc_busy) mon_q <= mon_level;
        end
    end

    assign dtack_n  = (state_q != S_ACK);
    assign rdata_oe = (state_q == S_ACK) && is_read_q;
    assign rdata    = rdata_oe ? rdata_q : 16'h0000;
    assign berr_n   = 1'b1;

    p_read_prompt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && strobe && hit && write_n) |=> !dtack_n);

    p_miss_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !hit) |=> dtack_n);

    p_hold_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_ACK && strobe && !write_n && hold) |=> dtack_n);

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && ds_n) |=> dtack_n);

    p_ack_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && !ds_n) |=> !dtack_n);
endmodule

// File: tb/sim_vme_slow_slave.sv
`timescale 1ns/1ps
module sim_vme_slow_slave;
    localparam int N_CH = 12, N_PH = 5;
    localparam int DAC_CYC = 30, PH_CYC = 60, ADC_CYC = 20, MON_W = 12;
    localparam logic [7:0] BSEL = 8'hA5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [5:0] am = '0;
    logic [7:0] a_hi = '0, a_word = '0;
    logic as_n = 1'b1, ds_n = 1'b1, write_n = 1'b1;
    logic [15:0] wdata = '0, rdata;
    logic rdata_oe, dtack_n, berr_n, enc_rst;
    logic interlock = 1'b0;
    logic [MON_W-1:0] mon_level = '0;
    logic [N_CH*8-1:0] laser_dac, thresh_dac;
    logic [N_PH*5-1:0] phase_dly;

    int n_cmp = 0, n_bad = 0;
    logic [15:0] v;
    int lat;

    vme_slow_slave #(.N_CH(N_CH), .N_PH(N_PH), .DAC_CYC(DAC_CYC), .PH_CYC(PH_CYC),
                     .ADC_CYC(ADC_CYC), .MON_W(MON_W)) u0 (
        .clk(clk), .rst_n(rst_n), .board_sel(BSEL), .am(am), .a_hi(a_hi),
        .a_word(a_word), .as_n(as_n), .ds_n(ds_n), .write_n(write_n),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .dtack_n(dtack_n),
        .berr_n(berr_n), .interlock(interlock), .mon_level(mon_level),
        .laser_dac(laser_dac), .thresh_dac(thresh_dac), .phase_dly(phase_dly),
        .enc_rst(enc_rst));

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // One bus cycle; lat = clocks to DTACK, 0 when never acknowledged.
    task automatic access(input logic wr, input logic [5:0] am_v, input logic [7:0] hi,
                          input logic [7:0] w, input logic [15:0] wd, input int max_wait,
                          output logic [15:0] rd, output int lt);
        @(negedge clk);
        am = am_v; a_hi = hi; a_word = w; wdata = wd; write_n = !wr;
        as_n = 1'b0; ds_n = 1'b0;
        lt = 0; rd = '0;
        forever begin
            @(posedge clk); lt++;
            @(negedge clk);
            if (!dtack_n) begin rd = rdata; break; end
            if (lt >= max_wait) begin lt = 0; break; end
        end
        as_n = 1'b1; ds_n = 1'b1; write_n = 1'b1;
        @(negedge clk);
        check("R4 release", dtack_n, 1'b1);
    endtask

    task automatic rd16(input logic [7:0] w, output logic [15:0] d, output int lt);
        access(1'b0, 6'h39, BSEL, w, 16'h0, 400, d, lt);
    endtask

    task automatic wr16(input logic [7:0] w, input logic [15:0] d, output int lt);
        logic [15:0] dummy;
        access(1'b1, 6'h39, BSEL, w, d, 400, dummy, lt);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_up();
    end

    initial begin
        logic [7:0] last_ph;
        idle(5);
        check("R4 reset dtack", dtack_n, 1'b1);
        check("R3 berr", berr_n, 1'b1);
        check("R10 reset dac", laser_dac, '0);
        check("R10 reset enc", enc_rst, 1'b0);
        rst_n = 1'b1;
        idle(2);

        rd16(8'h00, v, lat);
        check("R3 read latency", lat, 1);
        check("R11 status idle", v, 16'h0000);
        interlock = 1'b1;
        rd16(8'h00, v, lat);
        check("R11 interlock bit", v, 16'h0008);

        for (int a = 0; a < 64; a++) begin
            access(1'b0, 6'(a), BSEL, 8'h00, 16'h0, 6, v, lat);
            check("R1 modifier ack", lat, (a == 'h39 || a == 'h3D) ? 1 : 0);
        end
        access(1'b1, 6'h09, BSEL, 8'h10, 16'h00AA, 6, v, lat);
        check("R1 foreign write ack", lat, 0);
        check("R1 foreign write effect", laser_dac[7:0], 8'h00);
        for (int h = 0; h < 256; h++) begin
            access(1'b0, 6'h3D, 8'(h), 8'h00, 16'h0, 6, v, lat);
            check("R2 board select", lat, (h == BSEL) ? 1 : 0);
        end

        wr16(8'h13, 16'h005A, lat);
        check("R8 starting write prompt", lat, 1);
        rd16(8'h00, v, lat);
        check("R3 read while busy", lat, 1);
        check("R5 dac busy bit", v, 16'h000A);
        rd16(8'h13, v, lat);
        check("R5 laser readback", v, 16'h005A);
        check("R5 laser output", laser_dac[3*8 +: 8], 8'h5A);
        wr16(8'h22, 16'h0033, lat);
        check("R8 held write delayed", lat > 1, 1'b1);
        check("R8 held write bounded", lat <= DAC_CYC + 2, 1'b1);
        rd16(8'h00, v, lat);
        check("R5 new load busy", v, 16'h000A);
        rd16(8'h22, v, lat);
        check("R8 held write landed", v, 16'h0033);

        for (int i = 0; i < N_CH; i++) begin
            wr16(8'h10 + 8'(i), 16'((i * 19 + 7) & 255), lat);
            wr16(8'h20 + 8'(i), 16'((i * 23 + 3) & 255), lat);
        end
        for (int i = 0; i < N_CH; i++) begin
            rd16(8'h10 + 8'(i), v, lat);
            check("R5 laser sweep", v, (i * 19 + 7) & 255);
            rd16(8'h20 + 8'(i), v, lat);
            check("R5 thresh sweep", v, (i * 23 + 3) & 255);
            check("R5 laser pin", laser_dac[i*8 +: 8], (i * 19 + 7) & 255);
            check("R5 thresh pin", thresh_dac[i*8 +: 8], (i * 23 + 3) & 255);
        end

        wr16(8'h02, 16'h0003, lat);
        check("R10 enc_rst set", enc_rst, 1'b1);
        idle(2);
        check("R10 laser cleared", laser_dac, '0);
        check("R10 thresh cleared", thresh_dac, '0);
        rd16(8'h02, v, lat);
        check("R10 control readback", v, 16'h0003);
        wr16(8'h11, 16'h0044, lat);
        idle(2);
        rd16(8'h11, v, lat);
        check("R10 write lost while clear", v, 16'h0000);
        wr16(8'h02, 16'h0000, lat);
        check("R10 enc_rst clear", enc_rst, 1'b0);
        wr16(8'h11, 16'h0044, lat);
        rd16(8'h11, v, lat);
        check("R10 write after clear", v, 16'h0044);
        idle(DAC_CYC + 5);

        wr16(8'h30, 16'd7, lat);
        check("R7 dummy write prompt", lat, 1);
        rd16(8'h30, v, lat);
        check("R7 dummy leaves phase", v, 16'h0000);
        rd16(8'h00, v, lat);
        check("R7 dummy starts load", v, 16'h0009);
        wr16(8'h30, 16'd7, lat);
        check("R8 held by phase load", lat > 1, 1'b1);
        rd16(8'h30, v, lat);
        check("R6 phase stored", v, 16'd7);
        idle(PH_CYC + 5);
        wr16(8'h31, 16'd25, lat);
        check("R6 invalid prompt", lat, 1);
        rd16(8'h00, v, lat);
        check("R6 invalid no load", v, 16'h0008);
        rd16(8'h31, v, lat);
        check("R6 invalid discarded", v, 16'h0000);
        wr16(8'h34, 16'd24, lat);
        rd16(8'h34, v, lat);
        check("R6 top value", v, 16'd24);
        check("R6 phase pin", phase_dly[4*5 +: 5], 5'd24);

        last_ph = 8'd0;
        for (int p = 0; p < 32; p++) begin
            wr16(8'h32, 16'(p), lat);
            if (p <= 24) last_ph = 8'(p);
            rd16(8'h32, v, lat);
            check("R6 phase sweep", v, {8'h00, last_ph});
        end
        idle(PH_CYC + 5);

        mon_level = 12'h123;
        rd16(8'h01, v, lat);
        check("R9 first monitor read", v, 16'h0000);
        rd16(8'h00, v, lat);
        check("R9 adc busy bit", v, 16'h000C);
        rd16(8'h01, v, lat);
        check("R9 read during conversion", v, 16'h0000);
        idle(ADC_CYC + 5);
        rd16(8'h00, v, lat);
        check("R9 no restart", v, 16'h0008);
        rd16(8'h01, v, lat);
        check("R9 result", v, 16'h0123);
        mon_level = 12'h456;
        idle(ADC_CYC + 5);
        rd16(8'h01, v, lat);
        check("R9 second result", v, 16'h0456);
        idle(ADC_CYC + 5);

        wr16(8'h00, 16'hFFFF, lat);
        rd16(8'h00, v, lat);
        check("R11 status write ignored", v, 16'h0008);
        wr16(8'h01, 16'hFFFF, lat);
        rd16(8'h01, v, lat);
        check("R11 monitor write ignored", v, 16'h0456);
        interlock = 1'b0;
        idle(ADC_CYC + 5);
        rd16(8'h00, v, lat);
        check("R11 interlock low", v, 16'h0000);
        rd16(8'h80, v, lat);
        check("R3 unmapped word", v, 16'h0000);
        rd16(8'h1F, v, lat);
        check("R3 channel past end", v, 16'h0000);

        finish_up();
    end
endmodule